// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves the control-flow outcome of one decoded jump-class instruction for a single hardware thread. Each cycle in which the input is marked valid, it takes the thread's current program counter, the 3-bit jump opcode, the 18-bit offset field, the value already read from the condition/destination register, a select that picks the register value or the PC-relative address as the jump target, and the current return-address register. Exactly one clock later it presents the next program counter, a taken flag, an illegal-opcode flag and a return-address write (value plus enable).

Conditional branches test a whole register against zero rather than a flag set. Calls write the sequential address (PC plus the 4-byte instruction size) into a dedicated return-address register, and returns jump to that register. The PC-relative target is the current PC plus the sign-extended offset. Instruction fetch, register-file reads and pipeline flushing belong to the surrounding pipeline.

Top module: `flow_target_unit`

## Requirements
- R1: The outputs for an input accepted with `in_valid` high appear with `out_valid` high on the clock edge after it; a cycle without `in_valid` gives `out_valid` low on the following edge.
- R2: Opcode 0 (jump) is always taken; the next PC is `in_reg` when `in_use_reg` is 1, otherwise PC plus the sign-extended offset.
- R3: Opcode 1 (call) is taken with the same target choice as opcode 0 and also asserts `out_ra_we` with `out_ra_data` equal to PC+4.
- R4: Opcode 3 (return) is taken and the next PC equals `in_ra`.
- R5: Opcode 5 is taken to PC plus offset when `in_reg` is zero; otherwise it is not taken and the next PC is PC+4.
- R6: Opcode 6 is taken to PC plus offset when `in_reg` is nonzero; otherwise it is not taken and the next PC is PC+4.
- R7: The 18-bit offset is sign-extended from its bit 17 before it is added, so an offset with bit 17 set moves the PC backwards; the addition wraps modulo 2^32.
- R8: Opcodes 2, 4 and 7 give next PC = PC+4, taken 0, return-address write 0 and `out_illegal` 1.
- R9: While reset is asserted (`rst_n` low) and after its release, until the first valid input, `out_valid`, `out_taken`, `out_ra_we` and `out_illegal` are 0 and `out_npc` is 0.
- R10: `in_use_reg` has no effect for opcodes 3, 5 and 6: conditional branches always use PC plus offset and a return always uses `in_ra`.
- R11: `out_ra_we` is 1 only for opcode 1; every other opcode leaves it 0.
- R12: In a cycle after one without `in_valid`, `out_taken`, `out_ra_we` and `out_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decoded jump-class instruction is present |
| in_pc | input | 32 | Program counter of that instruction |
| in_op | input | 3 | Jump opcode |
| in_off | input | 18 | Signed byte offset field |
| in_reg | input | 32 | Value of the condition/destination register |
| in_use_reg | input | 1 | 1: opcodes 0 and 1 jump to `in_reg`; 0: to PC plus offset |
| in_ra | input | 32 | Current return-address register value |
| out_valid | output | 1 | Result below is valid |
| out_npc | output | 32 | Next program counter |
| out_taken | output | 1 | Control flow left the sequential path |
| out_ra_we | output | 1 | Write `out_ra_data` into the return-address register |
| out_ra_data | output | 32 | Return address (PC+4 of the instruction) |
| out_illegal | output | 1 | Opcode outside the defined jump set |

## Verification
Every result is due on the first rising edge after the cycle in which its input was presented, so each driven item is queued with its expected outcome and the monitor, which samples on the falling edge, pops and compares one item whenever `out_valid` is high; an `out_valid` with an empty queue or items left unmatched at the end count as mismatches. Reset state and the idle-cycle clearing of the flags are sampled on the falling edge one full cycle after the reset or idle input, covering exactly one register stage.

// File: rtl/flow_pkg.sv
package flow_pkg;

   // Jump-class opcode values; the encoding is fixed by the instruction set.
   typedef enum logic [2:0] {
      OP_JUMP   = 3'd0,
      OP_CALL   = 3'd1,
      OP_RET    = 3'd3,
      OP_BR_Z   = 3'd5,
      OP_BR_NZ  = 3'd6
   } jop_e;

   localparam int unsigned OP_W = 3;

   // Target source chosen by the decoder.
   typedef enum logic [1:0] {
      TGT_SEQ = 2'd0,
      TGT_REL = 2'd1,
      TGT_REG = 2'd2,
      TGT_RA  = 2'd3
   } tgt_e;

endpackage

// File: rtl/flow_off_ext.sv
module flow_off_ext #(
   parameter int unsigned OFF_W    = 18,
   parameter int unsigned ADDR_W   = 32,
   parameter bit          SIGN_OFF = 1'b1
) (
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] off_o
);
   localparam int unsigned PAD_W = ADDR_W - OFF_W;

   initial assert (OFF_W < ADDR_W)
      else $error("flow_off_ext: OFF_W must be narrower than ADDR_W");

   generate
      if (SIGN_OFF) begin : g_signed
         assign off_o = {{PAD_W{off_i[OFF_W-1]}}, off_i};
      end else begin : g_unsigned
         assign off_o = {{PAD_W{1'b0}}, off_i};
      end
   endgenerate
endmodule

// File: rtl/flow_decide.sv
module flow_decide #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [flow_pkg::OP_W-1:0] op_i,
   input  logic [ADDR_W-1:0]         cond_i,
   input  logic                      use_reg_i,
   output flow_pkg::tgt_e            tgt_o,
   output logic                      taken_o,
   output logic                      link_o,
   output logic                      bad_o
);
   import flow_pkg::*;

   logic is_zero;
   assign is_zero = (cond_i == '0);

   always_comb begin
      tgt_o   = TGT_SEQ;
      taken_o = 1'b0;
      link_o  = 1'b0;
      bad_o   = 1'b0;
      case (op_i)
         OP_JUMP: begin
            taken_o = 1'b1;
            tgt_o   = use_reg_i ? TGT_REG : TGT_REL;
         end
         OP_CALL: begin
            taken_o = 1'b1;
            link_o  = 1'b1;
            tgt_o   = use_reg_i ? TGT_REG : TGT_REL;
         end
         OP_RET: begin
            taken_o = 1'b1;
            tgt_o   = TGT_RA;
         end
         OP_BR_Z: begin
            taken_o = is_zero;
            tgt_o   = is_zero ? TGT_REL : TGT_SEQ;
         end
         OP_BR_NZ: begin
            taken_o = !is_zero;
            tgt_o   = is_zero ? TGT_SEQ : TGT_REL;
         end
         default: begin
            bad_o   = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/flow_tgt_mux.sv
module flow_tgt_mux #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] off_i,
   input  logic [ADDR_W-1:0] reg_i,
   input  logic [ADDR_W-1:0] ra_i,
   input  flow_pkg::tgt_e    sel_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] npc_o
);
   import flow_pkg::*;

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] rel;
   assign seq_o = pc_i + STEP_V;
   assign rel   = pc_i + off_i;

   always_comb begin
      case (sel_i)
         TGT_REL: npc_o = rel;
         TGT_REG: npc_o = reg_i;
         TGT_RA:  npc_o = ra_i;
         default: npc_o = seq_o;
      endcase
   end
endmodule

// File: rtl/flow_target_unit.sv
module flow_target_unit #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFF_W    = 18,
   parameter int unsigned STEP     = 4,
   parameter bit          SIGN_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_pc,
   input  logic [2:0]        in_op,
   input  logic [OFF_W-1:0]  in_off,
   input  logic [ADDR_W-1:0] in_reg,
   input  logic              in_use_reg,
   input  logic [ADDR_W-1:0] in_ra,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_npc,
   output logic              out_taken,
   output logic              out_ra_we,
   output logic [ADDR_W-1:0] out_ra_data,
   output logic              out_illegal
);
   import flow_pkg::*;

   initial assert (STEP > 0 && (STEP & (STEP - 1)) == 0)
      else $error("flow_target_unit: STEP must be a power of two");
   initial assert (ADDR_W >= 8)
      else $error("flow_target_unit: ADDR_W too small");

   logic [ADDR_W-1:0] off_x, seq_pc, npc_c;
   tgt_e              tgt_c;
   logic              taken_c, link_c, bad_c;

   flow_off_ext #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .SIGN_OFF(SIGN_OFF)) u_ext (
      .off_i (in_off),
      .off_o (off_x)
   );

   flow_decide #(.ADDR_W(ADDR_W)) u_dec (
      .op_i      (in_op),
      .cond_i    (in_reg),
      .use_reg_i (in_use_reg),
      .tgt_o     (tgt_c),
      .taken_o   (taken_c),
      .link_o    (link_c),
      .bad_o     (bad_c)
   );

   flow_tgt_mux #(.ADDR_W(ADDR_W), .STEP(STEP)) u_mux (
      .pc_i  (in_pc),
      .off_i (off_x),
      .reg_i (in_reg),
      .ra_i  (in_ra),
      .sel_i (tgt_c),
      .seq_o (seq_pc),
      .npc_o (npc_c)
   );

   // Flags are qualified by in_valid; data words hold between results.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_taken   <= 1'b0;
         out_ra_we   <= 1'b0;
         out_illegal <= 1'b0;
         out_npc     <= '0;
         out_ra_data <= '0;
      end else begin
         out_valid   <= in_valid;
         out_taken   <= in_valid & taken_c;
         out_ra_we   <= in_valid & link_c;
         out_illegal <= in_valid & bad_c;
         if (in_valid) begin
            out_npc     <= npc_c;
            out_ra_data <= seq_pc;
         end
      end
   end

   // R1: result valid exactly one edge after the input
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3: return-address data is the sequential address of the call
   a_r3_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd1) |=> (out_ra_we && out_ra_data == $past(in_pc) + ADDR_W'(STEP)));
   // R4: return follows the return-address register
   a_r4_return_target: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd3) |=> (out_taken && out_npc == $past(in_ra)));
   // R8: an illegal opcode is never taken and never links
   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_taken && !out_ra_we));
   // R11: a link write always belongs to a taken call
   a_r11_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
      out_ra_we |-> (out_taken && !out_illegal));
   // R12: flags only accompany a valid result
   a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken || out_ra_we || out_illegal) |-> out_valid);
endmodule

// File: tb/flow_target_unit_tb_top.sv
module flow_target_unit_tb_top;

   typedef struct {
      logic [31:0] npc;
      logic        taken;
      logic        ra_we;
      logic [31:0] ra_data;
      logic        illegal;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_pc = '0;
   logic [2:0]  in_op = '0;
   logic [17:0] in_off = '0;
   logic [31:0] in_reg = '0;
   logic        in_use_reg = 1'b0;
   logic [31:0] in_ra = '0;
   logic        out_valid, out_taken, out_ra_we, out_illegal;
   logic [31:0] out_npc, out_ra_data;

   int   n_cmp = 0;
   int   n_bad = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   flow_target_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
      .in_op(in_op), .in_off(in_off), .in_reg(in_reg),
      .in_use_reg(in_use_reg), .in_ra(in_ra), .out_valid(out_valid),
      .out_npc(out_npc), .out_taken(out_taken), .out_ra_we(out_ra_we),
      .out_ra_data(out_ra_data), .out_illegal(out_illegal)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] pc, input logic [2:0] op,
                                  input logic [17:0] off, input logic [31:0] rv,
                                  input logic ur, input logic [31:0] ra, input string tag);
      exp_t e;
      logic [31:0] seq, rel;
      seq = pc + 32'd4;
      rel = pc + {{14{off[17]}}, off};
      e.npc = seq; e.taken = 1'b0; e.ra_we = 1'b0; e.ra_data = seq;
      e.illegal = 1'b0; e.tag = tag;
      case (op)
         3'd0: begin e.taken = 1'b1; e.npc = ur ? rv : rel; end
         3'd1: begin e.taken = 1'b1; e.ra_we = 1'b1; e.npc = ur ? rv : rel; end
         3'd3: begin e.taken = 1'b1; e.npc = ra; end
         3'd5: if (rv == 0) begin e.taken = 1'b1; e.npc = rel; end
         3'd6: if (rv != 0) begin e.taken = 1'b1; e.npc = rel; end
         default: e.illegal = 1'b1;
      endcase
      return e;
   endfunction

   // Driver: one instruction per call, presented for one cycle.
   task automatic drive(input logic [31:0] pc, input logic [2:0] op,
                        input logic [17:0] off, input logic [31:0] rv,
                        input logic ur, input logic [31:0] ra, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_pc = pc; in_op = op; in_off = off;
      in_reg = rv; in_use_reg = ur; in_ra = ra;
      sb.push_back(model(pc, op, off, rv, ur, ra, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_op = 3'd1; in_reg = 32'h0;
      end
   endtask

   // Monitor: results sampled on the falling edge after their capture edge.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 actual=out_valid expected=no result");
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " npc"},     out_npc,            e.npc);
            chk({e.tag, " taken"},   {31'b0, out_taken}, {31'b0, e.taken});
            chk({e.tag, " R11 ra_we"}, {31'b0, out_ra_we}, {31'b0, e.ra_we});
            chk({e.tag, " illegal"}, {31'b0, out_illegal}, {31'b0, e.illegal});
            if (e.ra_we) chk({e.tag, " R3 ra_data"}, out_ra_data, e.ra_data);
         end
      end
   end

   initial begin
      fork
         begin
            #(8 * 20000);
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none

      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 valid", {31'b0, out_valid}, 32'd0);
      chk("R9 taken", {31'b0, out_taken}, 32'd0);
      chk("R9 ra_we", {31'b0, out_ra_we}, 32'd0);
      chk("R9 illegal", {31'b0, out_illegal}, 32'd0);
      chk("R9 npc", out_npc, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after release", {31'b0, out_valid}, 32'd0);

      // R2 jump
      drive(32'h0000_1000, 3'd0, 18'h00040, 32'hDEAD_BEE0, 1'b0, 32'h0, "R2 rel");
      drive(32'h0000_1000, 3'd0, 18'h00040, 32'hDEAD_BEE0, 1'b1, 32'h0, "R2 reg");
      // R3 call
      drive(32'h0000_2000, 3'd1, 18'h00100, 32'h0000_8000, 1'b0, 32'h0, "R3 rel");
      drive(32'h0000_2010, 3'd1, 18'h00100, 32'h0000_8000, 1'b1, 32'h0, "R3 reg");
      // R4 return, R10 use_reg ignored
      drive(32'h0000_3000, 3'd3, 18'h00008, 32'h1234_5678, 1'b0, 32'h0000_2014, "R4");
      drive(32'h0000_3000, 3'd3, 18'h00008, 32'h1234_5678, 1'b1, 32'h0000_2014, "R10 ret");
      // R5
      drive(32'h0000_4000, 3'd5, 18'h00020, 32'h0, 1'b0, 32'h0, "R5 zero");
      drive(32'h0000_4000, 3'd5, 18'h00020, 32'h8000_0000, 1'b0, 32'h0, "R5 nonzero");
      drive(32'h0000_4000, 3'd5, 18'h00020, 32'h0, 1'b1, 32'h0, "R10 bz");
      // R6
      drive(32'h0000_5000, 3'd6, 18'h00020, 32'h0000_0001, 1'b0, 32'h0, "R6 nonzero");
      drive(32'h0000_5000, 3'd6, 18'h00020, 32'h0, 1'b0, 32'h0, "R6 zero");
      drive(32'h0000_5000, 3'd6, 18'h00020, 32'h0000_0001, 1'b1, 32'h0, "R10 bnz");
      // R7 backward offset and wrap
      drive(32'h0000_6000, 3'd0, 18'h3FFF0, 32'h0, 1'b0, 32'h0, "R7 back");
      drive(32'h0000_0008, 3'd5, 18'h20000, 32'h0, 1'b0, 32'h0, "R7 wrap");
      drive(32'hFFFF_FFFC, 3'd6, 18'h00010, 32'h5, 1'b0, 32'h0, "R7 top");
      // R8 illegal opcodes
      drive(32'h0000_7000, 3'd2, 18'h00040, 32'h0, 1'b1, 32'h0, "R8 op2");
      drive(32'h0000_7000, 3'd4, 18'h00040, 32'h0, 1'b0, 32'h0, "R8 op4");
      drive(32'h0000_7000, 3'd7, 18'h00040, 32'h1, 1'b1, 32'h0, "R8 op7");
      // R12: idle cycle after a call with a taking condition present
      idle(1);
      @(negedge clk);
      chk("R12 valid", {31'b0, out_valid}, 32'd0);
      chk("R12 taken", {31'b0, out_taken}, 32'd0);
      chk("R12 ra_we", {31'b0, out_ra_we}, 32'd0);
      chk("R12 illegal", {31'b0, out_illegal}, 32'd0);
      // R1 after a gap
      drive(32'h0000_9000, 3'd1, 18'h00004, 32'h0, 1'b0, 32'h0, "R1 gap");
      idle(4);
      n_cmp++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R1 actual=%0d pending expected=0", sb.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule